// File: doc/BRIEF.md
# Interactive Receive Byte Path

This block sits behind a byte-level I2C receiver and in front of the register and DMA side of the controller. Each completed byte arrives with a strobe and three tags: address byte, general call response, or START byte response. In normal operation every byte goes into an 8-entry receive FIFO. The FIFO raises a DMA request once its fill level reaches a programmable threshold.

When the interactive switch is on, data bytes skip the FIFO and are captured in a holding register. A pending flag is raised and a clock-stretch request is held until firmware clears the flag. This lets firmware inspect each byte, for example a command, before more bytes arrive. While the flag is pending, firmware can turn the switch off and load a remaining-byte count, so the rest of the transfer flows through the FIFO. Suppose the held byte was never read when the switch goes off. Then the next read of the data port returns 0xFF as a marker. Bytes tagged as address, general call or START byte always take the FIFO path.

The remaining-byte counter counts down on data bytes and pulses a done output at zero, so the master can end the transfer with NACK and STOP.

Top module: `irx_byte_path`

## Requirements
- R1: A data byte (all three tags low) that arrives while `irx_en` is high is captured in the holding register and is not written to the FIFO. `irx_flag` is high from the next cycle.
- R2: `irx_flag` and `stretch_req` stay high until a `flag_clr` pulse. If a new interactive byte arrives in the same cycle as `flag_clr`, the flag stays set.
- R3: A read (`rd_en`) while the flag is pending and the held byte is unread returns the held byte and does not pop the FIFO. Any later read without a new interactive byte returns the FIFO head.
- R4: If `irx_en` is low while a held byte is still unread, the next read returns 0xFF without popping the FIFO. The read after that returns the FIFO head.
- R5: Bytes tagged as address, general call or START byte are written to the FIFO even while `irx_en` is high, and they leave `irx_flag` unchanged.
- R6: The FIFO holds up to 8 bytes in arrival order. Each read pops one entry and shows it on `rd_data` the cycle after `rd_en`. A read of an empty FIFO with nothing pending returns 0x00, and `fifo_level` stays unchanged.
- R7: `dma_req` is high exactly when `fifo_level` >= `rxth` (`rxth` from 1 to 8). It follows `fifo_level` in the same cycle, including the cycle in which the level drops below `rxth`.
- R8: A FIFO-bound byte that arrives while the FIFO is full (level 8 at the start of the cycle) is dropped and sets `ovf_flag`. `ovf_flag` stays high until an `ovf_clr` pulse.
- R9: A `flush` pulse empties the FIFO and cancels the 0xFF marker in one cycle. A FIFO-bound byte that arrives in the same cycle is discarded.
- R10: `cnt_load` loads `remain` from `cnt_val`. Each later data byte decrements it, and address-phase bytes do not. When it reaches zero, `cnt_done` is high for exactly one cycle. Loading zero produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is complete this cycle |
| rx_byte | input | 8 | Received byte value |
| rx_is_addr | input | 1 | Byte is an address byte |
| rx_is_gcall | input | 1 | Byte is a general call response |
| rx_is_startb | input | 1 | Byte is a START byte response |
| irx_en | input | 1 | Interactive receive switch |
| flag_clr | input | 1 | Clears the interactive pending flag |
| rd_en | input | 1 | Data port read strobe |
| rd_data | output | 8 | Read result, valid the cycle after rd_en |
| irx_flag | output | 1 | Interactive byte pending |
| stretch_req | output | 1 | Request to stall the bus |
| flush | input | 1 | Empty the FIFO and cancel the 0xFF marker |
| rxth | input | 4 | DMA threshold, 1 to 8 |
| fifo_level | output | 4 | FIFO fill level |
| dma_req | output | 1 | Receive DMA request |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Clears ovf_flag |
| cnt_load | input | 1 | Load the remaining-byte counter |
| cnt_val | input | 8 | Count to load |
| remain | output | 8 | Remaining-byte count |
| cnt_done | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
The FIFO path is swept over every fill level from 0 to 8. At each level every threshold from 1 to 8 is applied, which pins down the `>=` boundary of the DMA request on both sides, and the drained values confirm arrival order. The interactive path is driven with the following patterns:
- a held byte that is read, which separates the holding register from the FIFO head;
- a held byte that is abandoned, which separates the 0xFF marker from a pop;
- a tagged byte in interactive mode, which separates routing by tag from routing by mode;
- a clear that collides with a new byte, which exposes the set-over-clear priority.

The counter is run with address bytes mixed in and with a zero load, which separates data-byte counting from counting of every byte.

// File: rtl/irx_pkg.sv
package irx_pkg;
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_HOLD   = 2'd1,
    SRC_POISON = 2'd2,
    SRC_FIFO   = 2'd3
  } rd_src_e;
endpackage

// File: rtl/irx_fifo.sv
module irx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [LW-1:0]     level,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rptr];

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/irx_hold.sv
module irx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              cap,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              mode_en,
  input  logic              flag_clr,
  input  logic              rd_take,
  input  logic              poison_take,
  output logic [DATA_W-1:0] hold_data,
  output logic              flag,
  output logic              unread,
  output logic              poison
);
  logic abandon;
  assign abandon = !mode_en && unread && !rd_take && !cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_data <= '0;
      flag      <= 1'b0;
      unread    <= 1'b0;
      poison    <= 1'b0;
    end else begin
      if (cap) hold_data <= cap_data;

      if (cap)           flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;

      if (flush)                    unread <= 1'b0;
      else if (cap)                 unread <= 1'b1;
      else if (rd_take || abandon)  unread <= 1'b0;

      if (flush)            poison <= 1'b0;
      else if (abandon)     poison <= 1'b1;
      else if (poison_take) poison <= 1'b0;
    end
  end
endmodule

// File: rtl/irx_remain.sv
module irx_remain #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] remain,
  output logic             done
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      armed  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        remain <= load_val;
        armed  <= (load_val != '0);
      end else if (dec && armed) begin
        remain <= remain - 1'b1;
        if (remain == CNT_W'(1)) begin
          armed <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irx_byte_path.sv
module irx_byte_path #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_is_addr,
  input  logic              rx_is_gcall,
  input  logic              rx_is_startb,
  input  logic              irx_en,
  input  logic              flag_clr,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irx_flag,
  output logic              stretch_req,
  input  logic              flush,
  input  logic [LW-1:0]     rxth,
  output logic [LW-1:0]     fifo_level,
  output logic              dma_req,
  output logic              ovf_flag,
  input  logic              ovf_clr,
  input  logic              cnt_load,
  input  logic [CNT_W-1:0]  cnt_val,
  output logic [CNT_W-1:0]  remain,
  output logic              cnt_done
);
  import irx_pkg::*;

  logic              is_data, to_hold, to_fifo;
  logic              f_full, f_empty, f_pop;
  logic [DATA_W-1:0] f_head, h_data;
  logic              h_flag, h_unread, h_poison;
  logic              rd_take, poison_take;
  rd_src_e           src;

  assign is_data = !rx_is_addr && !rx_is_gcall && !rx_is_startb;
  assign to_hold = rx_valid && is_data && irx_en;
  assign to_fifo = rx_valid && !to_hold;

  assign rd_take     = rd_en && h_flag && h_unread;
  assign poison_take = rd_en && !rd_take && h_poison;
  assign f_pop       = rd_en && !rd_take && !h_poison;

  always_comb begin
    if (rd_take)        src = SRC_HOLD;
    else if (h_poison)  src = SRC_POISON;
    else if (!f_empty)  src = SRC_FIFO;
    else                src = SRC_NONE;
  end

  irx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush),
    .push(to_fifo), .push_data(rx_byte), .pop(f_pop),
    .head(f_head), .level(fifo_level), .full(f_full), .empty(f_empty)
  );

  irx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .flush(flush),
    .cap(to_hold), .cap_data(rx_byte), .mode_en(irx_en),
    .flag_clr(flag_clr), .rd_take(rd_take), .poison_take(poison_take),
    .hold_data(h_data), .flag(h_flag), .unread(h_unread), .poison(h_poison)
  );

  irx_remain #(.CNT_W(CNT_W)) u_remain (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val),
    .dec(rx_valid && is_data), .remain(remain), .done(cnt_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (rd_en) begin
        case (src)
          SRC_HOLD:   rd_data <= h_data;
          SRC_POISON: rd_data <= '1;
          SRC_FIFO:   rd_data <= f_head;
          default:    rd_data <= '0;
        endcase
      end
      if (to_fifo && f_full && !flush) ovf_flag <= 1'b1;
      else if (ovf_clr)                ovf_flag <= 1'b0;
    end
  end

  assign irx_flag    = h_flag;
  assign stretch_req = h_flag;
  assign dma_req     = (fifo_level >= rxth);
endmodule

// File: rtl/irx_byte_path_chk.sv
module irx_byte_path_chk #(
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_valid,
  input logic          rx_is_addr,
  input logic          rx_is_gcall,
  input logic          rx_is_startb,
  input logic          irx_en,
  input logic          flag_clr,
  input logic          rd_en,
  input logic          irx_flag,
  input logic          flush,
  input logic [LW-1:0] rxth,
  input logic [LW-1:0] fifo_level,
  input logic          dma_req,
  input logic          ovf_flag,
  input logic          ovf_clr,
  input logic          cnt_done
);
  a_r1_irx_skips_fifo: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && irx_en && !rx_is_addr && !rx_is_gcall && !rx_is_startb && !rd_en && !flush)
      |=> $stable(fifo_level));

  a_r2_flag_holds: assert property (@(posedge clk) disable iff (rst)
    (irx_flag && !flag_clr) |=> irx_flag);

  a_r6_level_bound: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= LW'(DEPTH));

  a_r7_dma_low: assert property (@(posedge clk) disable iff (rst)
    (fifo_level < rxth) |-> !dma_req);

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (fifo_level == '0));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    cnt_done |=> !cnt_done);
endmodule

bind irx_byte_path irx_byte_path_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_is_addr(rx_is_addr),
  .rx_is_gcall(rx_is_gcall), .rx_is_startb(rx_is_startb), .irx_en(irx_en),
  .flag_clr(flag_clr), .rd_en(rd_en), .irx_flag(irx_flag), .flush(flush),
  .rxth(rxth), .fifo_level(fifo_level), .dma_req(dma_req),
  .ovf_flag(ovf_flag), .ovf_clr(ovf_clr), .cnt_done(cnt_done)
);

// File: tb/sim_irx_byte_path.sv
`timescale 1ns/1ps
module sim_irx_byte_path;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 0, rx_is_addr = 0, rx_is_gcall = 0, rx_is_startb = 0;
  logic [7:0] rx_byte = 0;
  logic       irx_en = 0, flag_clr = 0, rd_en = 0, flush = 0, ovf_clr = 0, cnt_load = 0;
  logic [3:0] rxth = 4'd1;
  logic [7:0] cnt_val = 0;
  logic [7:0] rd_data, remain;
  logic [3:0] fifo_level;
  logic       irx_flag, stretch_req, dma_req, ovf_flag, cnt_done;
  int         n_chk = 0, n_fail = 0;
  bit         done_flag = 0;

  always #2.5 clk = ~clk;

  irx_byte_path u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_is_addr(rx_is_addr), .rx_is_gcall(rx_is_gcall), .rx_is_startb(rx_is_startb),
    .irx_en(irx_en), .flag_clr(flag_clr), .rd_en(rd_en), .rd_data(rd_data),
    .irx_flag(irx_flag), .stretch_req(stretch_req), .flush(flush), .rxth(rxth),
    .fifo_level(fifo_level), .dma_req(dma_req), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .remain(remain), .cnt_done(cnt_done)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // kind: 0 data, 1 address, 2 general call, 3 START byte
  task automatic send(input logic [7:0] b, input int kind);
    rx_byte = b; rx_valid = 1;
    rx_is_addr = (kind == 1); rx_is_gcall = (kind == 2); rx_is_startb = (kind == 3);
    step();
    rx_valid = 0; rx_is_addr = 0; rx_is_gcall = 0; rx_is_startb = 0;
  endtask

  task automatic rd();
    rd_en = 1; step(); rd_en = 0;
  endtask

  task automatic pulse_flush();
    flush = 1; step(); flush = 0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1; step(); flag_clr = 0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk); step(); step();
    rst = 0; step();

    // reset state
    check("R6 reset level", fifo_level, 0);
    check("R2 reset flag", irx_flag, 0);
    check("R2 reset stretch", stretch_req, 0);
    check("R7 reset dma", dma_req, 0);
    check("R8 reset ovf", ovf_flag, 0);
    check("R10 reset done", cnt_done, 0);

    // R6/R7 sweep over every level and threshold
    for (int k = 0; k <= 8; k++) begin
      pulse_flush();
      for (int i = 0; i < k; i++) send(8'(8'h20 + 16 * k + i), 0);
      check("R6 level", fifo_level, k);
      for (int th = 1; th <= 8; th++) begin
        rxth = 4'(th); #1;
        check("R7 dma vs threshold", dma_req, (k >= th) ? 1 : 0);
      end
      rxth = 4'(k == 0 ? 1 : k);
      for (int i = 0; i < k; i++) begin
        rd();
        check("R6 order", rd_data, 8'(8'h20 + 16 * k + i));
        check("R7 dma drops with level", dma_req, ((k - i - 1) >= k) ? 1 : 0);
      end
    end
    rd();
    check("R6 empty read", rd_data, 0);
    check("R6 empty level", fifo_level, 0);

    // R8 overflow
    for (int i = 0; i < 8; i++) send(8'(8'h60 + i), 0);
    check("R8 no ovf when just full", ovf_flag, 0);
    send(8'hEE, 0);
    check("R8 level stays full", fifo_level, 8);
    check("R8 ovf set", ovf_flag, 1);
    step();
    check("R8 ovf sticky", ovf_flag, 1);
    for (int i = 0; i < 8; i++) begin
      rd();
      check("R8 kept bytes", rd_data, 8'(8'h60 + i));
    end
    ovf_clr = 1; step(); ovf_clr = 0;
    check("R8 ovf cleared", ovf_flag, 0);

    // R1 R2 R3 R5
    irx_en = 1;
    send(8'hA1, 1);
    check("R5 address byte to FIFO", fifo_level, 1);
    check("R5 no flag on address", irx_flag, 0);
    send(8'h5A, 0);
    check("R1 level unchanged", fifo_level, 1);
    check("R1 flag set", irx_flag, 1);
    check("R2 stretch set", stretch_req, 1);
    step(); step();
    check("R2 flag held", irx_flag, 1);
    check("R2 stretch held", stretch_req, 1);
    rd();
    check("R3 held byte", rd_data, 8'h5A);
    check("R3 no pop", fifo_level, 1);
    rd();
    check("R3 then head", rd_data, 8'hA1);
    check("R3 popped", fifo_level, 0);
    pulse_clr();
    check("R2 flag cleared", irx_flag, 0);
    check("R2 stretch cleared", stretch_req, 0);
    send(8'hB2, 2);
    send(8'hC3, 3);
    check("R5 gcall and start bytes queued", fifo_level, 2);
    check("R5 flag untouched", irx_flag, 0);
    rd(); check("R5 gcall value", rd_data, 8'hB2);
    rd(); check("R5 start value", rd_data, 8'hC3);

    // R2 set wins over clear
    send(8'h11, 0);
    rx_byte = 8'h12; rx_valid = 1; flag_clr = 1; step();
    rx_valid = 0; flag_clr = 0;
    check("R2 set beats clear", irx_flag, 1);
    rd(); check("R1 newest held", rd_data, 8'h12);
    pulse_clr();

    // R4 abandoned held byte
    send(8'h33, 1);
    send(8'h77, 0);
    irx_en = 0; step();
    rd();
    check("R4 marker", rd_data, 8'hFF);
    check("R4 no pop", fifo_level, 1);
    rd();
    check("R4 then head", rd_data, 8'h33);
    pulse_clr();

    // R9 flush cancels marker and drops a same-cycle push
    irx_en = 1;
    send(8'h44, 1);
    send(8'h55, 0);
    irx_en = 0; step();
    pulse_flush();
    check("R9 level zero", fifo_level, 0);
    send(8'h66, 0);
    rd();
    check("R9 marker cancelled", rd_data, 8'h66);
    pulse_clr();
    rx_byte = 8'h99; rx_valid = 1; flush = 1; step();
    rx_valid = 0; flush = 0;
    check("R9 same-cycle push dropped", fifo_level, 0);
    check("R9 flush not overflow", ovf_flag, 0);

    // R10 remaining counter
    cnt_val = 8'd3; cnt_load = 1; step(); cnt_load = 0;
    check("R10 loaded", remain, 3);
    send(8'h01, 1);
    check("R10 address not counted", remain, 3);
    send(8'h02, 0);
    send(8'h03, 0);
    check("R10 count down", remain, 1);
    check("R10 no early done", cnt_done, 0);
    send(8'h04, 0);
    check("R10 reached zero", remain, 0);
    check("R10 done pulse", cnt_done, 1);
    step();
    check("R10 done one cycle", cnt_done, 0);
    send(8'h05, 0);
    check("R10 idle after zero", remain, 0);
    check("R10 no second pulse", cnt_done, 0);
    cnt_val = 8'd0; cnt_load = 1; step(); cnt_load = 0;
    send(8'h06, 0);
    check("R10 zero load no pulse", cnt_done, 0);

    finish_run();
  end
endmodule